// File: doc/BRIEF.md
# Speech Onset Detector with Fixed-Length Segment Capture

This block watches a stream of unsigned 8-bit audio magnitudes and decides when a spoken word starts. It splits the stream into back-to-back windows of 1024 accepted samples and forms the mean of each window. It then compares each window mean with the mean of the window just before it. Background noise gives means that stay roughly level. A word gives a sudden step up. When the newer mean is larger than the older one by more than a programmable threshold, the block flags the onset.

Once the onset is flagged, the block stops looking for onsets. It forwards the next 5120 accepted samples, which is 1.024 s at a 5 kHz sample rate, as a framed output stream, with the final sample marked. After the segment the detector stays idle until an arm strobe restarts it. On restart it begins from a fresh window and keeps no earlier mean. A quiet input whose level never steps up by more than the threshold never starts a capture.

Top module: `speech_onset_det`

## Requirements
- R1: While reset is asserted and after its release, `onset_pulse`, `seg_active`, `cap_valid` and `cap_last` are low and the detector is armed.
- R2: A window mean is the sum of 1024 accepted samples shifted right by 10 bits, so fractions are truncated. For example, 512 samples of 16 and 512 samples of 15 give a mean of 15.
- R3: An onset requires the new mean to be strictly greater than the previous mean plus `thresh`. A rise of exactly `thresh` is not an onset.
- R4: The first window after reset or arm is never compared, because no previous mean exists yet. A loud first window therefore cannot start a capture.
- R5: A falling or unchanged window mean never produces an onset.
- R6: `onset_pulse` is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample of the triggering window. `seg_active` rises in that same cycle.
- R7: The segment is the 5120 accepted samples that follow the triggering window, in arrival order. Each one appears on `cap_data` with `cap_valid` one cycle after its accepting edge. Cycles with `smp_valid` low are skipped and do not count.
- R8: `cap_last` is high only together with the 5120th segment sample. `seg_active` is low in that cycle, and no sample after it is forwarded.
- R9: After a segment ends, no onset or capture happens until `arm` is pulsed. After the arm pulse, detection starts with an empty window and no stored previous mean.
- R10: `arm` has no effect while the block is detecting or capturing. No onset is reported while a segment is being captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Sample strobe; `smp_data` is accepted on a rising edge where this is high |
| smp_data | input | 8 | Unsigned sample magnitude |
| thresh | input | 8 | Required rise of the window mean over the previous mean |
| arm | input | 1 | Restarts detection when the block is idle |
| onset_pulse | output | 1 | One-cycle onset flag |
| seg_active | output | 1 | High while a segment is being captured |
| cap_valid | output | 1 | A segment sample is present on `cap_data` |
| cap_data | output | 8 | Segment sample |
| cap_last | output | 1 | Marks the final segment sample |

## Verification
The sample that closes a window is accepted on one rising edge, and `onset_pulse` and `seg_active` respond in the cycle right after that edge. Every segment sample appears on `cap_data` one cycle after the edge that accepted it. The bench drives inputs on the falling edge. It counts accepted samples on the rising edge and reads the outputs on the next falling edge, so each result is compared with the number of the sample that caused it. Onset timing is checked against an exact sample index, for example 5120 after five windows. Capture order and length are checked across gaps in `smp_valid`.

// File: rtl/sod_pkg.sv
package sod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DETECT  = 2'd1,
    ST_CAPTURE = 2'd2
  } sod_state_e;
endpackage

// File: rtl/sod_win_avg.sv
// Accumulates one window of samples and presents its truncated mean
// in the cycle the closing sample is accepted.
module sod_win_avg #(
  parameter int SAMPLE_W = 8,
  parameter int WIN_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                win_done,
  output logic [SAMPLE_W-1:0] win_mean
);
  localparam int ACC_W = SAMPLE_W + WIN_LOG2;

  logic [ACC_W-1:0]    acc_q, acc_d, sum;
  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic                take;

  always_comb begin
    take     = en && smp_valid && !clr;
    sum      = acc_q + ACC_W'(smp_data);
    win_done = take && (cnt_q == '1);
    win_mean = sum[ACC_W-1 -: SAMPLE_W];
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = win_done ? '0 : sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R9: a cleared window starts empty
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && acc_q == '0));
  // R2: closing a window restarts the sample count
  p_window_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (cnt_q == '0));
endmodule

// File: rtl/sod_onset_cmp.sv
// Holds the previous window mean and flags a rise beyond the threshold.
module sod_onset_cmp #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                win_done,
  input  logic [SAMPLE_W-1:0] win_mean,
  input  logic [SAMPLE_W-1:0] thresh,
  output logic                rise_hit
);
  logic [SAMPLE_W-1:0] prev_q, prev_d;
  logic                have_q, have_d;
  logic [SAMPLE_W:0]   bar;

  always_comb begin
    bar      = {1'b0, prev_q} + {1'b0, thresh};
    rise_hit = win_done && have_q && ({1'b0, win_mean} > bar);
    prev_d   = prev_q;
    have_d   = have_q;
    if (clr) begin
      prev_d = '0;
      have_d = 1'b0;
    end else if (win_done) begin
      prev_d = win_mean;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  // R4: a reference mean exists once a window has closed
  p_reference_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !clr) |=> have_q);
  // R9: clearing drops the reference mean
  p_reference_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !have_q);
endmodule

// File: rtl/sod_seg_capture.sv
// Forwards a fixed number of accepted samples with valid/last framing.
module sod_seg_capture #(
  parameter int SAMPLE_W = 8,
  parameter int SEG_LEN  = 5120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                seg_done,
  output logic                cap_valid,
  output logic [SAMPLE_W-1:0] cap_data,
  output logic                cap_last
);
  localparam int CNT_W = $clog2(SEG_LEN + 1);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                take;
  logic                vld_d, last_d;
  logic [SAMPLE_W-1:0] dat_d;

  always_comb begin
    take     = en && smp_valid;
    seg_done = take && (cnt_q == CNT_W'(SEG_LEN - 1));
    cnt_d    = cnt_q;
    if (!en)           cnt_d = '0;
    else if (seg_done) cnt_d = '0;
    else if (take)     cnt_d = cnt_q + 1'b1;
    vld_d  = take;
    last_d = seg_done;
    dat_d  = take ? smp_data : cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cap_valid <= 1'b0;
      cap_last  <= 1'b0;
      cap_data  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      cap_valid <= vld_d;
      cap_last  <= last_d;
      cap_data  <= dat_d;
    end
  end

  // R7: the segment counter never passes the segment length
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(SEG_LEN));
  // R8: the last marker only accompanies a forwarded sample
  p_last_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |-> cap_valid);
endmodule

// File: rtl/speech_onset_det.sv
module speech_onset_det
  import sod_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WIN_LOG2 = 10,
  parameter int SEG_LEN  = 5120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                arm,
  output logic                onset_pulse,
  output logic                seg_active,
  output logic                cap_valid,
  output logic [SAMPLE_W-1:0] cap_data,
  output logic                cap_last
);
  sod_state_e          state_q, state_d;
  logic                detecting, win_done, rise_hit, seg_done, onset_d;
  logic [SAMPLE_W-1:0] win_mean;

  assign detecting  = (state_q == ST_DETECT);
  assign seg_active = (state_q == ST_CAPTURE);

  sod_win_avg #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(!detecting), .en(detecting),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .win_done(win_done), .win_mean(win_mean)
  );

  sod_onset_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(!detecting), .win_done(win_done),
    .win_mean(win_mean), .thresh(thresh), .rise_hit(rise_hit)
  );

  sod_seg_capture #(.SAMPLE_W(SAMPLE_W), .SEG_LEN(SEG_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(seg_active),
    .smp_valid(smp_valid), .smp_data(smp_data), .seg_done(seg_done),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_last(cap_last)
  );

  always_comb begin
    state_d = state_q;
    onset_d = 1'b0;
    unique case (state_q)
      ST_DETECT: if (rise_hit) begin
        state_d = ST_CAPTURE;
        onset_d = 1'b1;
      end
      ST_CAPTURE: if (seg_done) state_d = ST_IDLE;
      ST_IDLE:    if (arm)      state_d = ST_DETECT;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_DETECT;
      onset_pulse <= 1'b0;
    end else begin
      state_q     <= state_d;
      onset_pulse <= onset_d;
    end
  end

  // R6: onset is a single-cycle pulse
  p_onset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    onset_pulse |=> !onset_pulse);
  // R6: onset opens the segment in the same cycle
  p_onset_opens_seg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    onset_pulse |-> seg_active);
  // R8: the final sample closes the segment
  p_last_closes_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |-> !seg_active);
  // R10: no onset while a segment is in progress
  p_quiet_in_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_active |=> !onset_pulse);
  // R9: idle persists until armed
  p_idle_until_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm) |=> (state_q == ST_IDLE));
endmodule

// File: tb/speech_onset_det_tb.sv
module speech_onset_det_tb;
  logic       clk = 1'b0;
  logic       rst_n, smp_valid, arm;
  logic [7:0] smp_data, thresh;
  logic       onset_pulse, seg_active, cap_valid, cap_last;
  logic [7:0] cap_data;

  speech_onset_det u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .arm(arm), .onset_pulse(onset_pulse),
    .seg_active(seg_active), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_last(cap_last)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int sent, onset_cnt, onset_at, onset_seg, cap_n, last_idx, seg_err;
  bit done = 0;
  logic [7:0] cap_buf [0:5119];

  always @(negedge clk) begin
    if (rst_n) begin
      if (onset_pulse) begin
        onset_cnt++;
        onset_at  = sent;
        onset_seg = int'(seg_active);
      end
      if (cap_valid) begin
        if (cap_n < 5120) cap_buf[cap_n] = cap_data;
        if (cap_last) last_idx = cap_n;
        if (cap_last == seg_active) seg_err++;
        cap_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v;
    arm       = 1'b0;
    @(posedge clk);
    sent++;
  endtask

  task automatic idle(input int n, input bit a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      arm       = a;
      @(posedge clk);
    end
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic send_win(input logic [7:0] v);
    for (int i = 0; i < 1024; i++) send(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; arm = 1'b0; smp_data = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(!onset_pulse && !seg_active && !cap_valid && !cap_last, "R1 outputs in reset",
        int'({onset_pulse, seg_active, cap_valid, cap_last}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    sent = 0; onset_cnt = 0; onset_at = -1; onset_seg = 0;
    cap_n = 0; last_idx = -1; seg_err = 0;
    @(negedge clk);
    chk(!onset_pulse && !seg_active && !cap_valid, "R1 outputs after release",
        int'({onset_pulse, seg_active, cap_valid}), 0);
  endtask

  // Onset rules, timing and one full segment
  task automatic t_detect_and_capture();
    int mism;
    thresh = 8'd20;
    send_win(8'd200); idle(1, 0);
    chk(onset_cnt == 0, "R4 first window not compared", onset_cnt, 0);
    send_win(8'd200);
    send_win(8'd220); idle(1, 0);
    chk(onset_cnt == 0, "R3 rise equal to thresh", onset_cnt, 0);
    send_win(8'd100); idle(1, 0);
    chk(onset_cnt == 0, "R5 falling mean", onset_cnt, 0);
    send_win(8'd121); idle(1, 0);
    chk(onset_cnt == 1 && onset_at == 5120, "R6 onset index", onset_at, 5120);
    chk(onset_seg == 1, "R6 seg_active with onset", onset_seg, 1);
    chk(cap_n == 0, "R7 nothing before segment", cap_n, 0);
    for (int k = 0; k < 5120; k++) begin
      if (k % 97 == 50) idle(3, 0);
      if (k == 2000) idle(1, 1);   // arm while capturing: R10
      send(pat(k));
    end
    idle(3, 0);
    mism = 0;
    for (int k = 0; k < 5120; k++) if (cap_buf[k] !== pat(k)) mism++;
    chk(cap_n == 5120, "R7 segment length", cap_n, 5120);
    chk(mism == 0, "R7 segment order", mism, 0);
    chk(last_idx == 5119, "R8 last marker index", last_idx, 5119);
    chk(seg_err == 0 && !seg_active, "R8 seg_active framing", seg_err, 0);
    chk(onset_cnt == 1, "R10 no onset or restart from arm in capture", onset_cnt, 1);
    send_win(8'd0); send_win(8'd255); idle(2, 0);
    chk(onset_cnt == 1 && cap_n == 5120, "R9 idle without arm", cap_n, 5120);
  endtask

  // Re-arm starts fresh; arm mid-detection ignored
  task automatic t_rearm();
    int base;
    idle(1, 1);
    base = sent;
    send_win(8'd200); idle(1, 0);
    chk(onset_cnt == 1, "R9 no stale mean after arm", onset_cnt, 1);
    for (int i = 0; i < 1024; i++) begin
      if (i == 500) idle(1, 1);
      send(8'd10);
    end
    send_win(8'd200); idle(1, 0);
    chk(onset_cnt == 2 && onset_at == base + 3072, "R10 arm ignored while detecting",
        onset_at, base + 3072);
  endtask

  // Truncating window mean
  task automatic t_truncation();
    int base;
    thresh = 8'd5;
    base = sent;
    send_win(8'd10); send_win(8'd10);
    for (int i = 0; i < 512; i++) send(8'd16);
    for (int i = 0; i < 512; i++) send(8'd15);
    idle(1, 0);
    chk(onset_cnt == 0, "R2 mean 15.5 truncates to 15", onset_cnt, 0);
    send_win(8'd21); idle(1, 0);
    chk(onset_cnt == 1 && onset_at == base + 4096, "R2 onset against mean 15",
        onset_at, base + 4096);
  endtask

  initial begin
    thresh = '0;
    do_reset();
    t_detect_and_capture();
    t_rearm();
    do_reset();
    t_truncation();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule